// File: doc/BRIEF.md
# Windowed Offset-Frequency Counter with Decimal Readout

This block measures how far a tuned oscillator sits below a fixed reference and presents the result as a four-digit decimal number. A single flip-flop samples the squared oscillator signal on every reference-clock edge. Its output carries the difference between the two frequencies, so the reading falls as the oscillator rises toward the reference. The rising edges of that difference signal are counted in decimal.

A divider on the reference produces a slot tick. A display-enable strobe toggles on every tick, and the readout is meant to be lit while the strobe is high. Edges are counted only in a blanking slot (strobe low). To keep the least significant digit from flickering, only one blanking slot in every 2^(TAP_BASE+tap_sel+1) slots is used for counting. A short clear pulse zeroes the digit counters just before each counting slot opens. When the strobe next rises, the finished count is copied to the output register.

With the default parameters the tick rate is 100 Hz, so a counting slot lasts 10 ms and one count step stands for 100 Hz. A smaller TICK_DIV shortens every interval in proportion.

Top module: `freq_window_counter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `digits` is 0, `disp_en` is low and `count_win` is low.
- R2: `disp_en` is a square wave whose level changes exactly every TICK_DIV clock cycles. It starts low after reset and goes high on the first tick.
- R3: `count_win` is high only while `disp_en` is low. Each window lasts exactly TICK_DIV cycles, and it opens and closes only on tick edges.
- R4: Successive window openings are 2^(TAP_BASE+tap_sel+1)*TICK_DIV cycles apart. `tap_sel` is a two-bit unsigned value, so 0 gives the shortest interval and each increment doubles it.
- R5: `sig_in` passes through the sampling flip-flop and two further stages. The count for a window is the number of rising edges of the sampled signal that fall inside it. An input held low gives 0.
- R6: The digit counters are zeroed just before every window, so a reading never includes edges from an earlier window.
- R7: `digits` is packed BCD with the thousands digit in bits [15:12], hundreds in [11:8], tens in [7:4] and units in [3:0]. Decimal carries ripple between the digits.
- R8: A count that would pass 9999 stays at 9999.
- R9: `digits` changes only on the clock after a rising edge of `disp_en`. Between updates it holds its value, including across display slots that had no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also samples the input |
| rst | input | 1 | Synchronous reset, active high |
| sig_in | input | 1 | Squared oscillator signal, asynchronous |
| tap_sel | input | 2 | Selects the update interval between counting windows |
| digits | output | 16 | Latched four-digit packed BCD reading |
| disp_en | output | 1 | Display-enable strobe; high means show, low means blank |
| count_win | output | 1 | High while edges are being counted |

## Verification
A fault in the slot divider or the interval counter shows up at the ports within one interval: the window is too long or too short, falls on a displayed slot, or opens at the wrong spacing. A missed clear or a broken carry first appears in the reading latched at the end of the next window, either as a sum of two windows or as a non-decimal digit. A latch that fires at the wrong time is caught at the next rising edge of the display strobe, because the reading changes when no window has closed.

// File: rtl/freq_window_counter.sv
module freq_window_counter #(
  parameter int TICK_DIV = 27000,
  parameter int TAP_BASE = 3,
  parameter int CLR_LEN  = 27
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sig_in,
  input  logic [1:0]  tap_sel,
  output logic [15:0] digits,
  output logic        disp_en,
  output logic        count_win
);
  localparam int CW = $clog2(TICK_DIV);
  localparam int RW = TAP_BASE + 4;

  logic [CW-1:0] div_q;
  logic [RW-1:0] slot_q;
  logic          tick, tick_d, tap, clr, edge_p;
  logic          mix_q, s1_q, s2_q;
  logic [15:0]   cnt_q;

  function automatic logic [15:0] bcd_inc(input logic [15:0] v);
    logic [15:0] r;
    logic        c;
    r = v;
    c = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (c) begin
        if (r[i*4 +: 4] == 4'd9) r[i*4 +: 4] = 4'd0;
        else begin
          r[i*4 +: 4] = r[i*4 +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
    return r;
  endfunction

  assign tick   = (div_q == CW'(TICK_DIV - 1));
  assign tap    = slot_q[TAP_BASE + int'(tap_sel)];
  assign clr    = tap && disp_en && (div_q >= CW'(TICK_DIV - CLR_LEN));
  assign edge_p = s1_q && !s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= '0;
      disp_en   <= 1'b0;
      count_win <= 1'b0;
      slot_q    <= '0;
      tick_d    <= 1'b0;
    end else begin
      tick_d <= tick;
      if (tick) begin
        div_q     <= '0;
        disp_en   <= !disp_en;
        count_win <= tap;
        if (tap) slot_q <= '0;
        else if (!disp_en) slot_q <= slot_q + RW'(1);
      end else begin
        div_q <= div_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mix_q <= 1'b0;
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
    end else begin
      mix_q <= sig_in;
      s1_q  <= mix_q;
      s2_q  <= s1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      digits <= '0;
    end else begin
      if (clr) cnt_q <= '0;
      else if (count_win && edge_p && cnt_q != 16'h9999) cnt_q <= bcd_inc(cnt_q);
      if (tick_d && disp_en) digits <= cnt_q;
    end
  end

  // R3
  win_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
    count_win |-> !disp_en);
  // R3
  win_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $changed(count_win) |-> $past(tick));
  // R6
  clr_before_win_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && tick) |=> count_win);
  // R6
  clr_not_in_win_chk: assert property (@(posedge clk) disable iff (rst)
    clr |-> !count_win);
  // R7
  bcd_digit_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q[3:0] <= 4'd9 && cnt_q[7:4] <= 4'd9 && cnt_q[11:8] <= 4'd9 && cnt_q[15:12] <= 4'd9);
  // R9
  hold_when_blank_chk: assert property (@(posedge clk) disable iff (rst)
    !disp_en |-> $stable(digits));
endmodule

// File: tb/freq_window_counter_tb.sv
module freq_window_counter_tb;
  localparam int TD_A = 50;
  localparam int TB_A = 1;
  localparam int TD_B = 21000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_a = 1'b0, sig_b = 1'b0;
  logic [1:0] sel_a = 2'd1;
  logic [15:0] dig_a, dig_b;
  logic de_a, de_b, win_a, win_b;

  int checks = 0, errors = 0, cyc = 0;
  int per_a = 0, ph_a = 0, per_b = 0, ph_b = 0;
  int q_a[$], q_b[$];
  bit done_a = 0, done_b = 0, done_i = 0;

  always #10 clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  freq_window_counter #(.TICK_DIV(TD_A), .TAP_BASE(TB_A), .CLR_LEN(5)) u_dut (
    .clk(clk), .rst(rst), .sig_in(sig_a), .tap_sel(sel_a),
    .digits(dig_a), .disp_en(de_a), .count_win(win_a));

  freq_window_counter #(.TICK_DIV(TD_B), .TAP_BASE(0), .CLR_LEN(5)) u_dut_sat (
    .clk(clk), .rst(rst), .sig_in(sig_b), .tap_sel(2'd0),
    .digits(dig_b), .disp_en(de_b), .count_win(win_b));

  always @(negedge clk) begin
    if (per_a == 0) sig_a <= 1'b0;
    else begin ph_a = (ph_a + 1) % per_a; sig_a <= (ph_a < per_a / 2); end
    if (per_b == 0) sig_b <= 1'b0;
    else begin ph_b = (ph_b + 1) % per_b; sig_b <= (ph_b < per_b / 2); end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_a(input int p, input int exp);
    per_a = p; ph_a = 0;
    q_a.push_back(exp);
    @(negedge clk);
    while (!win_a) @(negedge clk);
    while (win_a) @(negedge clk);
  endtask

  task automatic drive_b(input int p, input int exp);
    per_b = p; ph_b = 0;
    q_b.push_back(exp);
    @(negedge clk);
    while (!win_b) @(negedge clk);
    while (win_b) @(negedge clk);
  endtask

  // monitor A: R2, R3, R9 and scoreboard pops
  initial begin
    bit pw = 0, pd = 0, post = 0, dr = 0;
    int wlen = 0, dlen = 0, last = 0;
    @(negedge rst);
    forever begin
      @(negedge clk);
      if (post) begin
        post = 0;
        if (q_a.size() > 0) check("R5/R6/R7 reading", int'(dig_a), q_a.pop_front());
        last = dig_a;
      end else if (dr) begin
        check("R9 hold", int'(dig_a), last);
      end
      dr = 0;
      if (win_a) begin
        wlen++;
        if (de_a) check("R3 window in blank", 1, 0);
      end
      if (pw && !win_a) begin
        check("R3 window length", wlen, TD_A);
        wlen = 0;
        post = 1;
      end else if (!pd && de_a) dr = 1;
      dlen++;
      if (de_a != pd) begin
        if (cyc > TD_A + 2) check("R2 slot length", dlen, TD_A);
        dlen = 0;
      end
      pw = win_a; pd = de_a;
    end
  end

  // monitor B
  initial begin
    bit pw = 0, post = 0;
    @(negedge rst);
    forever begin
      @(negedge clk);
      if (post) begin
        post = 0;
        if (q_b.size() > 0) check("R7/R8 large reading", int'(dig_b), q_b.pop_front());
      end
      if (pw && !win_b) post = 1;
      pw = win_b;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1
    check("R1 reset digits", int'(dig_a), 0);
    check("R1 reset disp_en", int'(de_a), 0);
    check("R1 reset count_win", int'(win_a), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset digits", int'(dig_a), 0);
    check("R1 after reset disp_en", int'(de_a), 0);
    fork
      begin
        // R5 R6: distinct input periods, no accumulation
        drive_a(5, 'h10);
        drive_a(10, 'h5);
        drive_a(2, 'h25);
        drive_a(0, 'h0);
        drive_a(25, 'h2);
        drive_a(50, 'h1);
        // R4 interval for each tap
        for (int s = 0; s < 3; s++) begin
          int t0;
          sel_a = 2'(s);
          while (!win_a) @(negedge clk);
          while (win_a) @(negedge clk);
          while (!win_a) @(negedge clk);
          t0 = cyc;
          while (win_a) @(negedge clk);
          while (!win_a) @(negedge clk);
          check($sformatf("R4 interval sel=%0d", s), cyc - t0, (1 << (TB_A + s + 1)) * TD_A);
        end
        done_a = 1;
      end
      begin
        drive_b(3, 'h7000);
        drive_b(2, 'h9999);
        repeat (3) @(negedge clk);
        done_b = 1;
      end
    join
    repeat (3) @(negedge clk);
    check("R5 scoreboard drained", q_a.size() + q_b.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule